// File: doc/BRIEF.md
# Three-Stage Elastic Queue Pipeline

This block is a fixed three-step datapath. Each step has a one-entry queue on both sides in place of a plain pipeline register. Words enter through a valid/ready input into an entry queue. They pass through three arithmetic steps, each followed by its own queue:

- increment by one
- shift left by one bit
- XOR with a constant key

Results leave through a valid/ready output from the last queue.

Every queue is a one-entry queue that can be emptied and refilled in the same clock. Its "can accept" condition is true when it is empty, or when its current word is leaving this cycle. That condition is combinational and runs backwards from the output ready toward the input. Every step can therefore move in the same cycle. The pipeline streams one word per clock and fills without gaps after a downstream stall. A synchronous clear empties every queue at once, and it overrides any transfer in the same cycle.

Top module: `flow_pipe3`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `outValid` is 0 and `inReady` is 1.
- R2: Each delivered word equals `(((x + 1) mod 2^WIDTH) << 1 mod 2^WIDTH) XOR XOR_KEY` for its input word x. The default is WIDTH = 8 and XOR_KEY = 0x5A.
- R3: Words are delivered in acceptance order, with none lost or duplicated, under any pattern of `inValid` and `outReady`.
- R4: On an empty pipeline with `outReady` high, a word accepted in cycle c is presented on `outValid`/`outData` in cycle c+4.
- R5: With `inValid` and `outReady` both held high, `inReady` stays high. Once filled, the pipeline delivers one word in every cycle.
- R6: With `outReady` held low, exactly four words are accepted, and `inReady` then stays low.
- R7: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values into the next cycle.
- R8: When all four queues are full and `outReady` is high, `inReady` is high in that same cycle.
- R9: A cycle with `clear` high empties every queue. This includes a word handshaken at the input in that cycle. In the next cycle `outValid` is 0 and `inReady` is 1, and none of the discarded words is ever delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of all queues |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Pipeline accepts the offered word this cycle |
| inData | input | WIDTH | Input word |
| outValid | output | 1 | Result word available |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | WIDTH | Result word |

## Verification
All 256 input words are streamed at full rate, which separates transform errors from flow errors. Every 4-cycle periodic combination of input-valid and output-ready patterns is then swept, followed by a long pseudo-random run. These runs expose lost, duplicated or reordered words, and bubbles that only occur under particular stall phases. Directed sequences cover the remaining rules:

- the single-word fill latency
- the full-rate stream without gaps
- the exact four-word capacity
- the same-cycle reopening of a full pipeline
- a clear that coincides with an input handshake

// File: rtl/flow_pipe3_pkg.sv
package flow_pipe3_pkg;

  // number of one-entry queues: entry queue, two inter-step queues, exit queue
  localparam int NUM_Q = 4;

  // control-to-datapath strobes: one load per queue
  typedef struct packed {
    logic [NUM_Q-1:0] load;
  } pipe_strobe_t;

endpackage

// File: rtl/flow_pipe3_slot.sv
// Occupancy flag of a single one-entry queue. Clear wins over any transfer;
// a simultaneous load and drain leaves the slot occupied.
module flow_pipe3_slot (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic load,
  input  logic drain,
  output logic occupied
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupied <= 1'b0;
    end else if (clear) begin
      occupied <= 1'b0;
    end else if (load) begin
      occupied <= 1'b1;
    end else if (drain) begin
      occupied <= 1'b0;
    end
  end

endmodule

// File: rtl/flow_pipe3_ctrl.sv
// Flow control: occupancy per queue, backward ready chain, transfer strobes.
module flow_pipe3_ctrl
  import flow_pipe3_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output pipe_strobe_t strobe
);

  logic [NUM_Q-1:0] full;
  logic [NUM_Q-1:0] drain;
  logic [NUM_Q-1:0] canTake;
  logic [NUM_Q-1:0] load;

  // Ready ripples from the output back to the input: a queue can take a
  // word when it is empty or its own word leaves in this cycle.
  always_comb begin
    logic downRdy;
    downRdy = outReady;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      drain[i]   = full[i] & downRdy;
      canTake[i] = ~full[i] | drain[i];
      downRdy    = canTake[i];
    end
  end

  // A step fires exactly when its upstream queue drains into the next one.
  always_comb begin
    load[0] = inValid & canTake[0];
    for (int i = 1; i < NUM_Q; i++) begin
      load[i] = drain[i-1];
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : gSlot
    flow_pipe3_slot uSlot (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (clear),
      .load     (load[g]),
      .drain    (drain[g]),
      .occupied (full[g])
    );
  end

  assign strobe.load = load;
  assign inReady     = canTake[0];
  assign outValid    = full[NUM_Q-1];

endmodule

// File: rtl/flow_pipe3_data.sv
// Datapath: one word register per queue, each fed by its step function.
module flow_pipe3_data
  import flow_pipe3_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] XOR_KEY = 'h5A
) (
  input  logic             clk,
  input  pipe_strobe_t     strobe,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] outData
);

  logic [WIDTH-1:0] word [NUM_Q];
  logic [WIDTH-1:0] nextWord [NUM_Q];

  // step applied on the way into queue idx
  function automatic logic [WIDTH-1:0] stepFn(input int idx, input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] r;
    case (idx)
      1:       r = x + WIDTH'(1);
      2:       r = x << 1;
      3:       r = x ^ XOR_KEY;
      default: r = x;
    endcase
    return r;
  endfunction

  for (genvar g = 0; g < NUM_Q; g++) begin : gWord
    if (g == 0) begin : gHead
      assign nextWord[g] = inData;
    end else begin : gStep
      assign nextWord[g] = stepFn(g, word[g-1]);
    end

    always_ff @(posedge clk) begin
      if (strobe.load[g]) begin
        word[g] <= nextWord[g];
      end
    end
  end

  assign outData = word[NUM_Q-1];

endmodule

// File: rtl/flow_pipe3.sv
// Thin top: control and datapath joined by the strobe struct.
module flow_pipe3
  import flow_pipe3_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] XOR_KEY = 'h5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [WIDTH-1:0] outData
);

  pipe_strobe_t strobe;

  flow_pipe3_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  flow_pipe3_data #(
    .WIDTH   (WIDTH),
    .XOR_KEY (XOR_KEY)
  ) uData (
    .clk     (clk),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/flow_pipe3_chk.sv
// Port-level checker: tracks how many words are inside via the handshakes.
module flow_pipe3_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [WIDTH-1:0] outData
);

  logic [3:0] occ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ <= '0;
    end else if (clear) begin
      occ <= '0;
    end else begin
      occ <= occ + 4'(inValid && inReady) - 4'(outValid && outReady);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occ <= 4'd4); // R6

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (occ == 4'd4 && !outReady) |-> !inReady); // R6

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (occ == 4'd0) |-> !outValid); // R3

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !clear) |=> (outValid && $stable(outData))); // R7

  AST_DRAIN_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (occ == 4'd4 && outReady) |-> inReady); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!outValid && inReady)); // R9

endmodule

bind flow_pipe3 flow_pipe3_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clear    (clear),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/flow_pipe3_bench.sv
module flow_pipe3_bench;

  localparam int             W   = 8;
  localparam logic [W-1:0]   KEY = 8'h5A;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         clear = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] inData = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [W-1:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] seq = '0;

  always #5 clk = ~clk;

  flow_pipe3 #(.WIDTH(W), .XOR_KEY(KEY)) u_flow_pipe3 (
    .clk(clk), .rstN(rstN), .clear(clear),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] x);
    logic [W-1:0] a, b;
    a = x + 8'd1;
    b = a << 1;
    return b ^ KEY;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, sample after settling,
  // account for handshakes that complete at the next rising edge.
  task automatic cycle(input bit v, input bit r, input logic [W-1:0] d, input string req);
    @(negedge clk);
    clear = 1'b0; inValid = v; outReady = r; inData = d;
    #1;
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, req, int'(outData), -1);
      end else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        check(outData == e, req, int'(outData), int'(e));
      end
    end
    if (inValid && inReady) expQ.push_back(model(d));
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 8; k++) cycle(1'b0, 1'b1, '0, req);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stimulus
    int firstSeen, accepted, bubbles;
    logic [W-1:0] held;
    bit haveHeld;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(outValid == 1'b0, "R1", outValid, 0);
    check(inReady == 1'b1, "R1", inReady, 1);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(outValid == 1'b0, "R1", outValid, 0);
    check(inReady == 1'b1, "R1", inReady, 1);

    // R2: every input value at full rate
    for (int x = 0; x < 256; x++) cycle(1'b1, 1'b1, W'(x), "R2");
    drain("R2");

    // R4: fill latency of one word on an empty pipeline
    cycle(1'b1, 1'b1, 8'h33, "R4");
    firstSeen = -1;
    for (int k = 1; k <= 8; k++) begin
      cycle(1'b0, 1'b1, '0, "R4");
      if (outValid && firstSeen < 0) firstSeen = k;
    end
    check(firstSeen == 4, "R4", firstSeen, 4);

    // R5: continuous streaming without gaps
    bubbles = 0;
    for (int k = 0; k < 40; k++) begin
      cycle(1'b1, 1'b1, W'(k * 7), "R5");
      if (!inReady) bubbles++;
      if (k >= 4 && !outValid) bubbles++;
    end
    check(bubbles == 0, "R5", bubbles, 0);
    drain("R5");

    // R6 / R7: capacity under a stalled consumer, held output
    accepted = 0; haveHeld = 0; held = '0;
    for (int k = 0; k < 10; k++) begin
      cycle(1'b1, 1'b0, W'(100 + k), "R6");
      if (inValid && inReady) accepted++;
      if (outValid) begin
        if (!haveHeld) begin held = outData; haveHeld = 1; end
        else check(outData == held, "R7", int'(outData), int'(held));
      end
    end
    check(accepted == 4, "R6", accepted, 4);
    check(inReady == 1'b0, "R6", inReady, 0);

    // R8: full pipeline reopens in the cycle the consumer becomes ready
    cycle(1'b1, 1'b1, 8'hC3, "R8");
    check(inReady == 1'b1, "R8", inReady, 1);
    drain("R8");

    // R9: clear discards stored words and a coinciding input word
    for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, W'(200 + k), "R9");
    @(negedge clk);
    clear = 1'b1; inValid = 1'b1; outReady = 1'b0; inData = 8'hEE;
    @(negedge clk);
    clear = 1'b0; inValid = 1'b0; outReady = 1'b0;
    #1;
    check(outValid == 1'b0, "R9", outValid, 0);
    check(inReady == 1'b1, "R9", inReady, 1);
    expQ.delete();
    for (int k = 0; k < 6; k++) begin
      cycle(1'b0, 1'b1, '0, "R9");
      check(outValid == 1'b0, "R9", outValid, 0);
    end
    cycle(1'b1, 1'b1, 8'h11, "R9");
    drain("R9");

    // R3: every 4-cycle periodic valid/ready pattern pair
    for (int vm = 0; vm < 16; vm++) begin
      for (int rm = 0; rm < 16; rm++) begin
        for (int k = 0; k < 16; k++) begin
          cycle(vm[k % 4], rm[k % 4], seq, "R3");
          if (inValid && inReady) seq++;
        end
        drain("R3");
      end
    end

    // R3: pseudo-random traffic
    void'($urandom(32'h1234));
    for (int k = 0; k < 3000; k++) begin
      cycle(1'($urandom % 2), 1'(($urandom % 4) != 0), W'($urandom), "R3");
    end
    drain("R3");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule